// File: doc/BRIEF.md
# VGA Colour Bar Test Pattern Generator

This block drives a 640x480 VGA monitor from a 25 MHz pixel clock. It produces active-low horizontal and vertical sync and a 6-bit colour output with 2 bits per channel. It paints one of two test patterns. In the first, vertical stripes 8 pixels wide step through 64 colours along each line. In the second, horizontal bands 4 lines tall step through the same 64 colours down the screen. In both patterns the colour sequence wraps back to its first entry after 64 steps.

A pixel counter and a line counter sweep the frame. Each colour is the 6-bit stripe or band number, taken straight from the relevant counter. The pattern select is sampled once per frame, so a frame never shows both patterns. All outputs are registered and follow the counter position by one clock. Every timing value and the stripe and band sizes are parameters. The defaults give the standard 800x525 frame.

Top module: `vga_bar_gen`

## Requirements
- R1: Each line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (default 800) and each frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (default 525). Counting restarts at pixel 0 of line 0 when reset is released.
- R2: `hsync_n` is 0 exactly for pixel positions H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1 of every line, and 1 elsewhere.
- R3: `vsync_n` is 0 for every pixel of lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1, and 1 elsewhere.
- R4: `rgb` is 0 whenever the pixel position is 640 or more, or the line is 480 or more.
- R5: With the frame's pattern select at 0 (stripes), a visible pixel at column x shows `rgb` = (x >> COL_LOG2) mod 64. With the default COL_LOG2=3 this gives 8-pixel stripes that wrap after 64 colours. The layout is `rgb[5:4]` red, `[3:2]` green and `[1:0]` blue.
- R6: With the frame's pattern select at 1 (bands), a visible pixel on line y shows `rgb` = (y >> ROW_LOG2) mod 64. With the default ROW_LOG2=2 this gives 4-line bands that wrap after 64 colours.
- R7: A frame uses the value of `mode` present on the clock that outputs the last pixel of the previous frame. For the first frame after reset, it uses the value present during reset. Changes of `mode` at any other time have no effect until the next frame starts.
- R8: While `rst` is high, `hsync_n`=1, `vsync_n`=1 and `rgb`=0. Each output belongs to the counter position of the previous clock, so the first clock after reset is released outputs pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| mode | input | 1 | pattern select: 0 stripes, 1 bands |
| hsync_n | output | 1 | horizontal sync, active low |
| vsync_n | output | 1 | vertical sync, active low |
| rgb | output | 6 | colour, 2 bits per channel |

## Verification
All three outputs are due one clock after the counter position they describe. Pixel p after reset release therefore appears after rising edge p+1. The bench counts rising edges since release and derives the line and pixel from that count. It compares every output at the falling edge that follows each rising edge. A pattern change is expected one clock after the rising edge that outputs the last pixel of the frame. The bench latches its own copy of `mode` at that edge, so the new pattern is checked from the next frame's first pixel.

// File: rtl/vga_bar_gen.sv
module vga_bar_gen #(
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int COL_LOG2 = 3,
  parameter int ROW_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic [5:0] rgb
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);
  localparam logic [HW-1:0] H_END = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_END = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_LIM = HW'(H_VIS);
  localparam logic [VW-1:0] V_LIM = VW'(V_VIS);
  localparam logic [HW-1:0] HS_LO = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_HI = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_LO = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_HI = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          mode_q;

  wire           h_last  = (hcnt == H_END);
  wire           v_last  = (vcnt == V_END);
  wire           visible = (hcnt < H_LIM) && (vcnt < V_LIM);
  wire           hs_on   = (hcnt >= HS_LO) && (hcnt < HS_HI);
  wire           vs_on   = (vcnt >= VS_LO) && (vcnt < VS_HI);
  wire [HW-1:0]  col     = hcnt >> COL_LOG2;
  wire [VW-1:0]  row     = vcnt >> ROW_LOG2;
  wire [5:0]     idx     = mode_q ? row[5:0] : col[5:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      vcnt    <= '0;
      mode_q  <= mode;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      rgb     <= '0;
    end else begin
      hcnt    <= h_last ? '0 : hcnt + 1'b1;
      if (h_last) vcnt <= v_last ? '0 : vcnt + 1'b1;
      if (h_last && v_last) mode_q <= mode;
      hsync_n <= ~hs_on;
      vsync_n <= ~vs_on;
      rgb     <= visible ? idx : '0;
    end
  end

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    h_last |=> (hcnt == '0)); // R1

  AST_HSYNC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> ($past(hcnt) >= HS_LO && $past(hcnt) < HS_HI)); // R2

  AST_VSYNC_LINE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hcnt != HW'(1)) |-> $stable(vsync_n)); // R3

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
    (rgb != '0) |-> ($past(hcnt) < H_LIM && $past(vcnt) < V_LIM)); // R4

  AST_MODE_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(hcnt == '0 && vcnt == '0) |-> $stable(mode_q)); // R7
endmodule

// File: tb/sim_vga_bar_gen.sv
module sim_vga_bar_gen;
  localparam int HV = 136, HF = 4, HS = 8, HB = 12;
  localparam int VV = 70,  VF = 3, VS = 2, VB = 5;
  localparam int CL = 1, RL = 0;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int FR = HT * VT;

  logic clk = 0, rst = 1, mode = 0;
  logic hsync_n, vsync_n;
  logic [5:0] rgb;
  int checks = 0, errors = 0;
  int n = 0;
  bit fmode = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vga_bar_gen #(.H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
                .COL_LOG2(CL), .ROW_LOG2(RL)) u0 (
    .clk(clk), .rst(rst), .mode(mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at pos %0d: actual %0d expected %0d", req, n - 1, act, exp);
    end
  endtask

  task automatic reset_cycles(input int k);
    rst = 1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk("R8 hsync", hsync_n, 1);
      chk("R8 vsync", vsync_n, 1);
      chk("R8 rgb", rgb, 0);
    end
    fmode = mode;
    n = 0;
    rst = 0;
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      int p, h, v, e;
      @(negedge clk);
      n++;
      p = (n - 1) % FR;
      h = p % HT;
      v = p / HT;
      chk("R1 R2 hsync", hsync_n, (h >= HV + HF && h < HV + HF + HS) ? 0 : 1);
      chk("R1 R3 vsync", vsync_n, (v >= VV + VF && v < VV + VF + VS) ? 0 : 1);
      if (h >= HV || v >= VV) chk("R4 rgb", rgb, 0);
      else if (!fmode) begin
        e = (h >> CL) % 64;
        chk("R5 R7 rgb", rgb, e);
      end else begin
        e = (v >> RL) % 64;
        chk("R6 R7 rgb", rgb, e);
      end
      if (p == FR - 1) fmode = mode;
    end
  endtask

  initial begin
    mode = 0;
    reset_cycles(3);
    step(FR / 2);
    mode = 1;
    step(FR - FR / 2);
    step(FR / 3);
    mode = 0;
    step(FR - FR / 3);
    step(FR + FR / 4);
    mode = 1;
    reset_cycles(2);
    step(FR + 50);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule